// File: doc/BRIEF.md
# Two-Stage Prescaled Countdown Timer

This block is a host-programmed interval timer built from two cascaded down-counting stages. A prescaler stage divides the reference clock into ticks, and a main stage counts those ticks down to zero. The host programs both reload values, starts and stops the timer with one-cycle strobes, and picks whether the timer halts at zero or reloads itself and runs again. An external trigger pulse can start the timer in place of the host once auto-start is armed.

Reaching the end of the count only sets a sticky interrupt flag, which drives the interrupt output when enabled, and updates the timer's own running and count state. It alters no other logic. The host can set or clear the flag directly. All control and status travel over a plain single-cycle write port and a combinational read port.

Top module: `pct_timer`

## Requirements
- R1: A synchronous active-low reset clears the running state, the count, the prescaler, the interrupt flag, the mode bits (periodic, auto-start, interrupt enable) and both reload values. After reset every address reads 0, and both `running_o` and `irq_o` are low.
- R2: With a prescaler reload P (0 to 4095, written to address 2), one prescaler tick lasts exactly 2P+1 clock cycles.
- R3: With a counter reload R (0 to 65535, written to address 3), the main count decrements once per tick. Expiry happens on the tick that finds the count at 0, which is (R+1)(2P+1) clock edges after the edge that applied the start.
- R4: In one-shot mode (mode bit 0 = 0), expiry clears the running state and the count stays at 0.
- R5: In periodic mode (mode bit 0 = 1), expiry reloads the count with R and the timer keeps running, so expiries repeat every (R+1)(2P+1) cycles.
- R6: Expiry sets a sticky interrupt flag, read at address 5 bit 0. A host write to address 5 loads the flag with data bit 0. If expiry and that write fall in the same cycle, expiry wins and the flag is 1.
- R7: `irq_o` is high exactly when the flag is set and the interrupt enable (mode bit 2) is set. The flag itself is set whether or not the enable is set.
- R8: A write to address 0 with bit 0 set starts the timer: it loads both stages from their reload values and sets the running state. A start while the timer is running restarts it from the reload values.
- R9: A write to address 0 with bit 1 set stops the timer and freezes the count without reloading it. A stop takes priority over a start strobe or a trigger in the same cycle.
- R10: A one-cycle pulse on `trig_i` starts the timer as in R8 only when auto-start (mode bit 1) is set. Otherwise it leaves the running state and the count unchanged.
- R11: The read map is as follows. Address 0 returns the running state in bit 0. Address 1 returns the mode bits. Address 2 returns the prescaler reload. Address 3 returns the counter reload. Address 4 returns the live count. Address 5 returns the flag. Addresses 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 16 | Read data, combinational from `rd_addr_i` |
| trig_i | input | 1 | External start pulse, used when auto-start is set |
| running_o | output | 1 | High while the timer counts |
| irq_o | output | 1 | Interrupt flag gated by its enable |

## Verification
The clocked properties assume three things about the inputs: writes are single-cycle strobes, the reset is held long enough to settle every register, and the reload values do not change while a check that compares against a past reload is in flight. The stimulus meets these assumptions in three ways. It drives every write for exactly one clock edge. It changes reloads only while the timer is stopped, before the next start. It pulses the trigger for a single cycle. The prescaler and counter reloads are swept over small values so that every expiry interval can be computed as (R+1)(2P+1) and counted edge by edge.

// File: rtl/pct_pkg.sv
package pct_pkg;

   // register addresses
   localparam int unsigned ADR_CTRL   = 0;
   localparam int unsigned ADR_MODE   = 1;
   localparam int unsigned ADR_PRESC  = 2;
   localparam int unsigned ADR_RELOAD = 3;
   localparam int unsigned ADR_COUNT  = 4;
   localparam int unsigned ADR_FLAG   = 5;

   // control strobe bit positions
   localparam int unsigned CTL_START  = 0;
   localparam int unsigned CTL_STOP   = 1;

   // mode word: bit 2 irq enable, bit 1 auto-start, bit 0 periodic
   typedef struct packed {
      logic irq_en;
      logic auto_en;
      logic periodic;
   } mode_t;

   localparam int unsigned MODE_W = $bits(mode_t);

endpackage

// File: rtl/pct_prescaler.sv
module pct_prescaler #(
   parameter int unsigned PRESC_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic               run_i,
   input  logic [PRESC_W-1:0] reload_i,
   output logic               tick_o
);

   localparam int unsigned DIV_W = PRESC_W + 1;

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] span;

   // an odd period 2P+1 comes from counting 2P down to 0
   assign span   = {reload_i, 1'b0};
   assign tick_o = run_i && (div_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (load_i) begin
         div_q <= span;
      end else if (run_i) begin
         if (div_q == '0) div_q <= span;
         else             div_q <= div_q - 1'b1;
      end
   end

   // stopped prescaler holds its phase
   AST_PRESC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !load_i) |=> $stable(div_q)); // R9

   // a running prescaler either wraps or decrements
   AST_PRESC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !load_i && div_q != '0) |=> (div_q == $past(div_q) - 1'b1)); // R2

endmodule

// File: rtl/pct_counter.sv
module pct_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             tick_i,
   input  logic             periodic_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic             running_o,
   output logic [CNT_W-1:0] count_o,
   output logic             expire_o
);

   logic             run_q;
   logic [CNT_W-1:0] cnt_q;

   assign expire_o  = run_q && tick_i && (cnt_q == '0);
   assign running_o = run_q;
   assign count_o   = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (stop_i) begin
         run_q <= 1'b0;
      end else if (start_i) begin
         run_q <= 1'b1;
         cnt_q <= reload_i;
      end else if (expire_o) begin
         if (periodic_i) cnt_q <= reload_i;
         else            run_q <= 1'b0;
      end else if (run_q && tick_i) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> !run_q); // R9

   AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> $stable(cnt_q)); // R9

   AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !stop_i) |=> (run_q && cnt_q == $past(reload_i))); // R8

   AST_TICK_DECR: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && tick_i && cnt_q != '0 && !start_i && !stop_i)
         |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3

   AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_o && !periodic_i && !start_i && !stop_i) |=> (!run_q && cnt_q == '0)); // R4

   AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_o && periodic_i && !start_i && !stop_i)
         |=> (run_q && cnt_q == $past(reload_i))); // R5

endmodule

// File: rtl/pct_regs.sv
module pct_regs
   import pct_pkg::*;
#(
   parameter int unsigned PRESC_W = 12,
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned DATA_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en_i,
   input  logic [ADDR_W-1:0]  wr_addr_i,
   input  logic [DATA_W-1:0]  wr_data_i,
   input  logic [ADDR_W-1:0]  rd_addr_i,
   output logic [DATA_W-1:0]  rd_data_o,
   input  logic               trig_i,
   input  logic               expire_i,
   input  logic               running_i,
   input  logic [CNT_W-1:0]   count_i,
   output logic               start_o,
   output logic               stop_o,
   output logic               periodic_o,
   output logic [PRESC_W-1:0] presc_reload_o,
   output logic [CNT_W-1:0]   cnt_reload_o,
   output logic               irq_o
);

   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(ADR_CTRL);
   localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(ADR_MODE);
   localparam logic [ADDR_W-1:0] A_PRESC  = ADDR_W'(ADR_PRESC);
   localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(ADR_RELOAD);
   localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(ADR_COUNT);
   localparam logic [ADDR_W-1:0] A_FLAG   = ADDR_W'(ADR_FLAG);

   mode_t              mode_q;
   logic [PRESC_W-1:0] presc_q;
   logic [CNT_W-1:0]   reload_q;
   logic               flag_q;

   logic wr_ctrl, wr_mode, wr_presc, wr_reload, wr_flag;

   assign wr_ctrl   = wr_en_i && (wr_addr_i == A_CTRL);
   assign wr_mode   = wr_en_i && (wr_addr_i == A_MODE);
   assign wr_presc  = wr_en_i && (wr_addr_i == A_PRESC);
   assign wr_reload = wr_en_i && (wr_addr_i == A_RELOAD);
   assign wr_flag   = wr_en_i && (wr_addr_i == A_FLAG);

   // strobes; the counter gives stop precedence
   assign start_o = (wr_ctrl && wr_data_i[CTL_START]) || (mode_q.auto_en && trig_i);
   assign stop_o  = wr_ctrl && wr_data_i[CTL_STOP];

   assign periodic_o     = mode_q.periodic;
   assign presc_reload_o = presc_q;
   assign cnt_reload_o   = reload_q;
   assign irq_o          = flag_q && mode_q.irq_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= '0;
         presc_q  <= '0;
         reload_q <= '0;
      end else begin
         if (wr_mode)   mode_q   <= mode_t'(wr_data_i[MODE_W-1:0]);
         if (wr_presc)  presc_q  <= wr_data_i[PRESC_W-1:0];
         if (wr_reload) reload_q <= wr_data_i[CNT_W-1:0];
      end
   end

   // expiry outranks a host write in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (expire_i) flag_q <= 1'b1;
      else if (wr_flag)  flag_q <= wr_data_i[0];
   end

   // zero-extended read views
   logic [DATA_W-1:0] presc_ext, reload_ext, count_ext, mode_ext, run_ext, flag_ext;

   if (DATA_W == PRESC_W) begin : g_presc_full
      assign presc_ext = presc_q;
   end else begin : g_presc_pad
      assign presc_ext = {{(DATA_W-PRESC_W){1'b0}}, presc_q};
   end

   if (DATA_W == CNT_W) begin : g_cnt_full
      assign reload_ext = reload_q;
      assign count_ext  = count_i;
   end else begin : g_cnt_pad
      assign reload_ext = {{(DATA_W-CNT_W){1'b0}}, reload_q};
      assign count_ext  = {{(DATA_W-CNT_W){1'b0}}, count_i};
   end

   assign mode_ext = {{(DATA_W-MODE_W){1'b0}}, mode_q};
   assign run_ext  = {{(DATA_W-1){1'b0}}, running_i};
   assign flag_ext = {{(DATA_W-1){1'b0}}, flag_q};

   always_comb begin
      unique case (rd_addr_i)
         A_CTRL:   rd_data_o = run_ext;
         A_MODE:   rd_data_o = mode_ext;
         A_PRESC:  rd_data_o = presc_ext;
         A_RELOAD: rd_data_o = reload_ext;
         A_COUNT:  rd_data_o = count_ext;
         A_FLAG:   rd_data_o = flag_ext;
         default:  rd_data_o = '0;
      endcase
   end

   AST_EXPIRE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      expire_i |=> flag_q); // R6

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !(wr_flag && !wr_data_i[0])) |=> flag_q); // R6

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q.irq_en |-> !irq_o); // R7

   AST_TRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i && !mode_q.auto_en && !wr_ctrl) |-> !start_o); // R10

endmodule

// File: rtl/pct_timer.sv
module pct_timer
   import pct_pkg::*;
#(
   parameter int unsigned PRESC_W = 12,
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned DATA_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic              trig_i,
   output logic              running_o,
   output logic              irq_o
);

   initial begin
      AST_PARAM_DATA: assert (DATA_W >= CNT_W && DATA_W >= PRESC_W && DATA_W > MODE_W)
         else $error("data width too narrow for register fields"); // R11
      AST_PARAM_ADDR: assert (ADDR_W >= 3)
         else $error("address width cannot hold the register map"); // R11
      AST_PARAM_STAGE: assert (PRESC_W >= 1 && CNT_W >= 1)
         else $error("stage widths must be positive"); // R2
   end

   logic               start, stop, periodic, tick, expire, running;
   logic [PRESC_W-1:0] presc_reload;
   logic [CNT_W-1:0]   cnt_reload, count;

   pct_regs #(
      .PRESC_W(PRESC_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) regs_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
      .trig_i(trig_i), .expire_i(expire), .running_i(running), .count_i(count),
      .start_o(start), .stop_o(stop), .periodic_o(periodic),
      .presc_reload_o(presc_reload), .cnt_reload_o(cnt_reload), .irq_o(irq_o)
   );

   pct_prescaler #(.PRESC_W(PRESC_W)) presc_i (
      .clk(clk), .rst_n(rst_n),
      .load_i(start && !stop), .run_i(running),
      .reload_i(presc_reload), .tick_o(tick)
   );

   pct_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk(clk), .rst_n(rst_n),
      .start_i(start), .stop_i(stop), .tick_i(tick), .periodic_i(periodic),
      .reload_i(cnt_reload),
      .running_o(running), .count_o(count), .expire_o(expire)
   );

   assign running_o = running;

endmodule

// File: tb/pct_timer_tb_top.sv
module pct_timer_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        trig = 1'b0;
   logic        running, irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pct_timer dut_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .rd_addr_i(rd_addr), .rd_data_o(rd_data),
      .trig_i(trig), .running_o(running), .irq_o(irq)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // called at a negedge; applied by the next posedge; returns at the following negedge
   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output int v);
      rd_addr = a;
      #1;
      v = int'(rd_data);
   endtask

   task automatic pulse_trig();
      trig = 1'b1;
      @(posedge clk);
      @(negedge clk);
      trig = 1'b0;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int v;
      int n;
      // ---------------- reset state (R1, R11)
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(running == 1'b0, "R1 running after reset", running, 0);
      chk(irq == 1'b0, "R1 irq after reset", irq, 0);
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), v);
         chk(v == 0, $sformatf("R1 addr %0d after reset", a), v, 0);
      end

      // ---------------- sweep one-shot intervals (R2, R3, R4, R6, R7)
      wr(3'd1, 16'd4);
      for (int p = 0; p < 4; p++) begin
         for (int r = 0; r < 4; r++) begin
            wr(3'd2, 16'(p));
            wr(3'd3, 16'(r));
            wr(3'd5, 16'd0);
            wr(3'd0, 16'd1);
            n = 0;
            while (!irq && n < 200) begin
               @(negedge clk);
               n++;
            end
            chk(n == (r + 1) * (2 * p + 1),
                $sformatf("R3 expiry edges p=%0d r=%0d", p, r), n, (r + 1) * (2 * p + 1));
            if (r == 0)
               chk(n == 2 * p + 1, $sformatf("R2 tick period p=%0d", p), n, 2 * p + 1);
            chk(running == 1'b0, "R4 one-shot halts", running, 0);
            rd(3'd4, v);
            chk(v == 0, "R4 count holds zero", v, 0);
            repeat (3) @(negedge clk);
            chk(irq == 1'b1, "R6 flag sticky", irq, 1);
         end
      end

      // ---------------- enable masks the output only (R7)
      wr(3'd1, 16'd0);
      wr(3'd2, 16'd0);
      wr(3'd3, 16'd0);
      wr(3'd5, 16'd0);
      wr(3'd0, 16'd1);
      @(negedge clk);
      chk(irq == 1'b0, "R7 masked irq low", irq, 0);
      rd(3'd5, v);
      chk(v == 1, "R7 flag set while masked", v, 1);
      wr(3'd1, 16'd4);
      chk(irq == 1'b1, "R7 irq after enable", irq, 1);

      // ---------------- host set/clear and collision (R6)
      wr(3'd5, 16'd0);
      rd(3'd5, v);
      chk(v == 0, "R6 host clear", v, 0);
      wr(3'd5, 16'd1);
      rd(3'd5, v);
      chk(v == 1 && irq == 1'b1, "R6 host set", v, 1);
      wr(3'd5, 16'd0);
      wr(3'd3, 16'd1);
      wr(3'd0, 16'd1);
      @(negedge clk);
      wr(3'd5, 16'd0);
      rd(3'd5, v);
      chk(v == 1, "R6 expiry beats clear", v, 1);

      // ---------------- periodic mode (R5)
      wr(3'd1, 16'd5);
      wr(3'd2, 16'd1);
      wr(3'd3, 16'd2);
      wr(3'd5, 16'd0);
      wr(3'd0, 16'd1);
      n = 0;
      while (!irq && n < 200) begin
         @(negedge clk);
         n++;
      end
      chk(n == 9, "R5 first period", n, 9);
      rd(3'd4, v);
      chk(v == 2, "R5 count reloaded", v, 2);
      wr(3'd5, 16'd0);
      n = 1;
      while (!irq && n < 200) begin
         @(negedge clk);
         n++;
      end
      chk(n == 9, "R5 second period", n, 9);
      chk(running == 1'b1, "R5 still running", running, 1);
      wr(3'd0, 16'd2);

      // ---------------- decrement, restart, stop (R3, R8, R9)
      wr(3'd1, 16'd4);
      wr(3'd3, 16'd10);
      wr(3'd5, 16'd0);
      wr(3'd0, 16'd1);
      repeat (10) @(negedge clk);
      rd(3'd4, v);
      chk(v == 7, "R3 count after three ticks", v, 7);
      wr(3'd0, 16'd1);
      rd(3'd4, v);
      chk(v == 10 && running == 1'b1, "R8 restart reloads", v, 10);
      repeat (7) @(negedge clk);
      wr(3'd0, 16'd2);
      rd(3'd4, v);
      chk(v == 8, "R9 stop freezes count", v, 8);
      chk(running == 1'b0, "R9 stop clears running", running, 0);
      repeat (10) @(negedge clk);
      rd(3'd4, v);
      chk(v == 8 && irq == 1'b0, "R9 count stays frozen", v, 8);
      wr(3'd0, 16'd3);
      rd(3'd4, v);
      chk(running == 1'b0, "R9 stop beats start", running, 0);
      chk(v == 8, "R9 count kept on start+stop", v, 8);

      // ---------------- trigger (R10, R9)
      pulse_trig();
      rd(3'd4, v);
      chk(running == 1'b0 && v == 8, "R10 trigger ignored", v, 8);
      wr(3'd1, 16'd6);
      pulse_trig();
      rd(3'd4, v);
      chk(running == 1'b1, "R10 trigger starts", running, 1);
      chk(v == 10, "R10 trigger loads reload", v, 10);
      wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'd2; trig = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; trig = 1'b0;
      rd(3'd4, v);
      chk(running == 1'b0, "R9 stop beats trigger", running, 0);
      chk(v == 10, "R9 count after stop with trigger", v, 10);

      // ---------------- read map (R11)
      wr(3'd2, 16'd4095);
      wr(3'd3, 16'd65535);
      rd(3'd1, v);
      chk(v == 6, "R11 mode readback", v, 6);
      rd(3'd2, v);
      chk(v == 4095, "R11 prescaler reload readback", v, 4095);
      rd(3'd3, v);
      chk(v == 65535, "R11 counter reload readback", v, 65535);
      rd(3'd6, v);
      chk(v == 0, "R11 unused addr 6", v, 0);
      rd(3'd7, v);
      chk(v == 0, "R11 unused addr 7", v, 0);

      // ---------------- reset mid-run (R1)
      wr(3'd1, 16'd4);
      wr(3'd2, 16'd3);
      wr(3'd3, 16'd3);
      wr(3'd5, 16'd1);
      wr(3'd0, 16'd1);
      repeat (5) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rd(3'd4, v);
      chk(running == 1'b0 && irq == 1'b0, "R1 reset mid-run", running, 0);
      chk(v == 0, "R1 count cleared", v, 0);
      rd(3'd1, v);
      chk(v == 0, "R1 mode cleared", v, 0);
      rd(3'd5, v);
      chk(v == 0, "R1 flag cleared", v, 0);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule